// File: doc/BRIEF.md
# Program-Disturb Fingerprint Sequencer

This block extracts a physical fingerprint from a flash array by stressing one page and watching its neighbour. After a start pulse it erases the block that holds both pages, so every neighbour bit reads 1. It then programs the target page over and over, and it reads the neighbour page after every single program operation. For each neighbour bit it keeps the program count at which that bit first read 0. Each bit's disturb threshold depends on manufacturing variation, so the vector of counts identifies the device. Each target/neighbour pair gives an independent signature.

The block stops when every neighbour bit has flipped or when the program count reaches the cap (10000 by default). It then streams one count per cycle in ascending bit order and ends with a single-cycle done pulse. A bit that never flipped reports 0. The flash side is an abstract port: a one-cycle request carries an operation code and a page address, and the flash answers with a one-cycle done. A read returns the whole page on the data input in the same cycle as its done.

Top module: `disturb_fp_seq`

## Requirements
- R1: After reset, busy, flReq, sigValid and sigDone are all 0.
- R2: After a start in idle, the first flash request is an erase (flOp = 0) addressed to the target page.
- R3: After the erase, requests alternate strictly. A program (flOp = 1) goes to the target page, and it is followed by exactly one read (flOp = 2) of the neighbour page before the next program.
- R4: The count recorded for a neighbour bit is the number of completed program operations at the read where that bit first returns 0.
- R5: Once a bit has been recorded, later reads of that bit do not change its count.
- R6: A bit that never reads 0 before the run ends reports a count of 0.
- R7: No more than MAX_ITER program operations are issued per run, and the run ends after the read that follows program MAX_ITER.
- R8: The run ends after the first read in which all neighbour bits have been recorded as flipped, so no further program is issued.
- R9: Results appear with sigValid high for PAGE_BITS consecutive cycles, with sigIndex running 0 to PAGE_BITS-1. sigDone is high for one cycle in the next cycle, and busy is 0 after it.
- R10: A start pulse while busy is 1 has no effect. The run does not restart and the results are unchanged.
- R11: Every flash request is a single-cycle pulse, and a new request is not issued until the previous one's done has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a fingerprint run (accepted only when idle) |
| tgtAddr | input | ADDR_W | Page to program repeatedly |
| nbrAddr | input | ADDR_W | Neighbour page to read |
| busy | output | 1 | Run in progress |
| flReq | output | 1 | One-cycle flash request |
| flOp | output | 2 | Operation: 0 erase, 1 program, 2 read |
| flAddr | output | ADDR_W | Page address of the request |
| flDone | input | 1 | One-cycle completion from flash |
| flRdData | input | PAGE_BITS | Neighbour page data, valid with flDone of a read |
| sigValid | output | 1 | Count output valid |
| sigIndex | output | IDX_W | Bit index of current count |
| sigCount | output | CNT_W | Program count for that bit, 0 if never flipped |
| sigDone | output | 1 | One-cycle end-of-run pulse |

## Verification
The hardest case to reach is the program cap. It needs ten thousand program/read rounds in which some neighbour bits never flip, while another bit flips exactly at the last allowed program. The bench's flash model gives each neighbour bit its own disturb threshold, with 0 meaning it never flips. One run sets a threshold equal to the cap next to never-flipping bits. That run checks the count at the boundary, the zero counts and the total number of programs. The early-stop and first-flip-only rules are reached with thresholds chosen so that bits stay at 0 for many reads after their first flip.

// File: rtl/disturb_fp_pkg.sv
package disturb_fp_pkg;
  typedef enum logic [1:0] {
    OP_ERASE = 2'd0,
    OP_PROG  = 2'd1,
    OP_READ  = 2'd2
  } flOpT;

  typedef struct packed {
    logic clrAll;
    logic incIter;
    logic capture;
    logic streamAdv;
    logic useNbr;
  } dpStrobeT;
endpackage

// File: rtl/disturb_fp_datapath.sv
module disturb_fp_datapath
  import disturb_fp_pkg::*;
#(
  parameter int PAGE_BITS = 16,
  parameter int ADDR_W    = 8,
  parameter int CNT_W     = 14,
  parameter int MAX_ITER  = 10000,
  localparam int IDX_W    = (PAGE_BITS > 1) ? $clog2(PAGE_BITS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrobeT             strb,
  input  logic [ADDR_W-1:0]    tgtAddr,
  input  logic [ADDR_W-1:0]    nbrAddr,
  input  logic [PAGE_BITS-1:0] rdData,
  output logic [ADDR_W-1:0]    flAddr,
  output logic                 allFlipped,
  output logic                 atCap,
  output logic                 streamLast,
  output logic [IDX_W-1:0]     streamIdx,
  output logic [CNT_W-1:0]     streamCnt
);
  logic [CNT_W-1:0]     iterCnt;
  logic [PAGE_BITS-1:0] flipped;
  logic [CNT_W-1:0]     bitCnt [PAGE_BITS];
  logic [ADDR_W-1:0]    tgtQ, nbrQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tgtQ <= '0;
      nbrQ <= '0;
    end else if (strb.clrAll) begin
      tgtQ <= tgtAddr;
      nbrQ <= nbrAddr;
    end
  end

  assign flAddr = strb.useNbr ? nbrQ : tgtQ;

  always_ff @(posedge clk) begin
    if (!rstN || strb.clrAll) iterCnt <= '0;
    else if (strb.incIter)    iterCnt <= iterCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.clrAll) begin
      flipped <= '0;
      for (int i = 0; i < PAGE_BITS; i++) bitCnt[i] <= '0;
    end else if (strb.capture) begin
      for (int i = 0; i < PAGE_BITS; i++) begin
        if (!flipped[i] && !rdData[i]) begin
          flipped[i] <= 1'b1;
          bitCnt[i]  <= iterCnt;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.clrAll) streamIdx <= '0;
    else if (strb.streamAdv)  streamIdx <= streamIdx + 1'b1;
  end

  assign allFlipped = &flipped;
  assign atCap      = (iterCnt == CNT_W'(MAX_ITER));
  assign streamLast = (streamIdx == IDX_W'(PAGE_BITS - 1));
  assign streamCnt  = bitCnt[streamIdx];

  // R7: program counter never passes the cap
  p_iter_cap_r7: assert property (@(posedge clk) disable iff (!rstN)
    iterCnt <= CNT_W'(MAX_ITER));

  // R5: a latched flip survives every cycle except a new-run clear
  p_flip_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clrAll |=> ((flipped & $past(flipped)) == $past(flipped)));
endmodule

// File: rtl/disturb_fp_ctrl.sv
module disturb_fp_ctrl
  import disturb_fp_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     flDone,
  input  logic     allFlipped,
  input  logic     atCap,
  input  logic     streamLast,
  output dpStrobeT strb,
  output logic     flReq,
  output flOpT     flOp,
  output logic     busy,
  output logic     sigValid,
  output logic     sigDone
);
  typedef enum logic [3:0] {
    S_IDLE, S_ERASE_REQ, S_ERASE_WAIT, S_PROG_REQ, S_PROG_WAIT,
    S_READ_REQ, S_READ_WAIT, S_EVAL, S_STREAM, S_FIN
  } stateT;

  stateT state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    flReq     = 1'b0;
    flOp      = OP_ERASE;
    sigValid  = 1'b0;
    sigDone   = 1'b0;
    unique case (state)
      S_IDLE: if (start) begin
        strb.clrAll = 1'b1;
        nextState   = S_ERASE_REQ;
      end
      S_ERASE_REQ: begin
        flReq     = 1'b1;
        flOp      = OP_ERASE;
        nextState = S_ERASE_WAIT;
      end
      S_ERASE_WAIT: if (flDone) nextState = S_PROG_REQ;
      S_PROG_REQ: begin
        flReq     = 1'b1;
        flOp      = OP_PROG;
        nextState = S_PROG_WAIT;
      end
      S_PROG_WAIT: if (flDone) begin
        strb.incIter = 1'b1;
        nextState    = S_READ_REQ;
      end
      S_READ_REQ: begin
        flReq       = 1'b1;
        flOp        = OP_READ;
        strb.useNbr = 1'b1;
        nextState   = S_READ_WAIT;
      end
      S_READ_WAIT: begin
        strb.useNbr = 1'b1;
        if (flDone) begin
          strb.capture = 1'b1;
          nextState    = S_EVAL;
        end
      end
      S_EVAL: nextState = (allFlipped || atCap) ? S_STREAM : S_PROG_REQ;
      S_STREAM: begin
        sigValid       = 1'b1;
        strb.streamAdv = 1'b1;
        if (streamLast) nextState = S_FIN;
      end
      S_FIN: begin
        sigDone   = 1'b1;
        nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);

  // R11: requests are single-cycle pulses
  p_req_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    flReq |=> !flReq);

  // R3: a completed program is followed by a neighbour read request
  p_read_after_prog_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_PROG_WAIT && flDone) |=> (flReq && flOp == OP_READ));

  // R9: the last streamed count is followed by the done pulse
  p_done_after_last_r9: assert property (@(posedge clk) disable iff (!rstN)
    (sigValid && streamLast) |=> (sigDone && !sigValid));
endmodule

// File: rtl/disturb_fp_seq.sv
module disturb_fp_seq
  import disturb_fp_pkg::*;
#(
  parameter int PAGE_BITS = 16,
  parameter int ADDR_W    = 8,
  parameter int CNT_W     = 14,
  parameter int MAX_ITER  = 10000,
  localparam int IDX_W    = (PAGE_BITS > 1) ? $clog2(PAGE_BITS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [ADDR_W-1:0]    tgtAddr,
  input  logic [ADDR_W-1:0]    nbrAddr,
  output logic                 busy,
  output logic                 flReq,
  output logic [1:0]           flOp,
  output logic [ADDR_W-1:0]    flAddr,
  input  logic                 flDone,
  input  logic [PAGE_BITS-1:0] flRdData,
  output logic                 sigValid,
  output logic [IDX_W-1:0]     sigIndex,
  output logic [CNT_W-1:0]     sigCount,
  output logic                 sigDone
);
  dpStrobeT strb;
  flOpT     opEnum;
  logic     allFlipped, atCap, streamLast;

  disturb_fp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .flDone(flDone),
    .allFlipped(allFlipped), .atCap(atCap), .streamLast(streamLast),
    .strb(strb), .flReq(flReq), .flOp(opEnum), .busy(busy),
    .sigValid(sigValid), .sigDone(sigDone)
  );

  disturb_fp_datapath #(
    .PAGE_BITS(PAGE_BITS), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .MAX_ITER(MAX_ITER)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .tgtAddr(tgtAddr), .nbrAddr(nbrAddr),
    .rdData(flRdData), .flAddr(flAddr), .allFlipped(allFlipped), .atCap(atCap),
    .streamLast(streamLast), .streamIdx(sigIndex), .streamCnt(sigCount)
  );

  assign flOp = opEnum;
endmodule

// File: tb/disturb_fp_seq_tb.sv
`timescale 1ns/1ps
module disturb_fp_seq_tb_top;
  localparam int NB   = 16;
  localparam int AW   = 8;
  localparam int CW   = 14;
  localparam int MAXI = 10000;
  localparam int IW   = 4;

  logic clk = 0, rstN = 0, start = 0;
  logic [AW-1:0] tgtAddr = 8'h21, nbrAddr = 8'h22;
  logic busy, flReq, flDone, sigValid, sigDone;
  logic [1:0] flOp;
  logic [AW-1:0] flAddr;
  logic [NB-1:0] flRdData;
  logic [IW-1:0] sigIndex;
  logic [CW-1:0] sigCount;

  always #2 clk = ~clk;

  disturb_fp_seq dut_i (
    .clk(clk), .rstN(rstN), .start(start), .tgtAddr(tgtAddr), .nbrAddr(nbrAddr),
    .busy(busy), .flReq(flReq), .flOp(flOp), .flAddr(flAddr), .flDone(flDone),
    .flRdData(flRdData), .sigValid(sigValid), .sigIndex(sigIndex),
    .sigCount(sigCount), .sigDone(sigDone)
  );

  int tests = 0, fails = 0;
  int thr [NB];

  // flash model
  int progCnt = 0, eraseCnt = 0, readCnt = 0, seqErr = 0, dblReq = 0;
  int lastOp = -1;
  bit pend = 0, prevReq = 0;
  int pendOp = 0;
  always @(posedge clk) begin
    flDone <= 1'b0;
    if (!rstN) begin
      pend = 0; prevReq = 0; flRdData <= '1;
    end else begin
      if (flReq) begin
        if (prevReq || pend) dblReq++;
        pendOp = flOp; pend = 1;
        if (flOp == 2'd0) begin
          if (lastOp != -1 || flAddr != tgtAddr) seqErr++;
        end else if (flOp == 2'd1) begin
          if (lastOp == 1 || lastOp == -1 || flAddr != tgtAddr) seqErr++;
        end else if (flOp == 2'd2) begin
          if (lastOp != 1 || flAddr != nbrAddr) seqErr++;
        end else seqErr++;
        lastOp = flOp;
      end else if (pend) begin
        pend = 0;
        flDone <= 1'b1;
        if (pendOp == 0) begin eraseCnt++; progCnt = 0; end
        else if (pendOp == 1) progCnt++;
        else begin
          readCnt++;
          for (int i = 0; i < NB; i++)
            flRdData[i] <= !(thr[i] != 0 && progCnt >= thr[i]);
        end
      end
      prevReq = flReq;
    end
  end

  // stream monitor
  int beats = 0, orderErr = 0, doneSeen = 0, doneBad = 0;
  logic [CW-1:0] got [NB];
  bit lastWasFinal = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (sigDone) begin
        doneSeen++;
        if (!lastWasFinal) doneBad++;
      end
      if (sigValid) begin
        if (int'(sigIndex) != beats) orderErr++;
        got[sigIndex] = sigCount;
        beats++;
      end
      lastWasFinal = sigValid && (int'(sigIndex) == NB - 1);
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clearModel();
    lastOp = -1; progCnt = 0; eraseCnt = 0; readCnt = 0; seqErr = 0; dblReq = 0;
    beats = 0; orderErr = 0; doneSeen = 0; doneBad = 0;
  endtask

  task automatic pulseStart();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  // run with current thr; optionally poke start mid-run
  task automatic runCase(input string name, input bit poke);
    int endIter, maxT, expC, cyc;
    bit allNz;
    clearModel();
    allNz = 1; maxT = 0;
    for (int i = 0; i < NB; i++) begin
      if (thr[i] == 0) allNz = 0;
      if (thr[i] > maxT) maxT = thr[i];
    end
    endIter = (allNz && maxT < MAXI) ? maxT : MAXI;
    pulseStart();
    if (poke) begin
      repeat (20) @(negedge clk);
      start = 1; @(negedge clk); start = 0;
    end
    cyc = 0;
    while (doneSeen == 0 && cyc < 150000) begin @(negedge clk); cyc++; end
    @(negedge clk);
    check("R9", {name, " done pulse count"}, doneSeen, 1);
    check("R9", {name, " done follows last beat"}, doneBad, 0);
    check("R9", {name, " beats"}, beats, NB);
    check("R9", {name, " index order errors"}, orderErr, 0);
    check("R9", {name, " busy after done"}, int'(busy), 0);
    check("R2", {name, " erase count"}, eraseCnt, 1);
    check("R3", {name, " sequence errors"}, seqErr, 0);
    check("R3", {name, " reads equal programs"}, readCnt, progCnt);
    check("R11", {name, " overlapping requests"}, dblReq, 0);
    check(allNz ? "R8" : "R7", {name, " programs issued"}, progCnt, endIter);
    for (int i = 0; i < NB; i++) begin
      expC = (thr[i] != 0 && thr[i] <= endIter) ? thr[i] : 0;
      check(expC == 0 ? "R6" : "R4", $sformatf("%s count bit %0d", name, i),
            int'(got[i]), expC);
    end
    if (poke) check("R10", {name, " restart ignored, erase"}, eraseCnt, 1);
  endtask

  task automatic t_reset();
    check("R1", "busy", int'(busy), 0);
    check("R1", "flReq", int'(flReq), 0);
    check("R1", "sigValid", int'(sigValid), 0);
    check("R1", "sigDone", int'(sigDone), 0);
  endtask

  task automatic t_mixed();
    // bits flip at scattered iterations and stay 0 afterwards (R5)
    for (int i = 0; i < NB; i++) thr[i] = ((i * 7) % NB) + 1;
    runCase("mixed R4 R5 R8", 1'b0);
  endtask

  task automatic t_uniform();
    for (int i = 0; i < NB; i++) thr[i] = 5;
    runCase("uniform R8", 1'b0);
  endtask

  task automatic t_busyStart();
    for (int i = 0; i < NB; i++) thr[i] = 30 - i;
    runCase("busy start R10", 1'b1);
  endtask

  task automatic t_cap();
    // never-flipping bits force the cap; bit 3 flips exactly at the cap
    for (int i = 0; i < NB; i++) thr[i] = (i % 4 == 0) ? 0 : i * 100;
    thr[3] = MAXI;
    runCase("cap R6 R7", 1'b0);
  endtask

  initial begin
    for (int i = 0; i < NB; i++) thr[i] = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_mixed();
    t_uniform();
    t_busyStart();
    t_cap();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(4ns * 199000);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule